// File: doc/BRIEF.md
# Quad-Output Serial Flash Read Controller

This block is the host side of a fast read from a serial NOR flash in which data returns on four lines. A start pulse is accepted together with a 24-bit start address and a byte count. The controller then lowers chip select and toggles the serial clock. On data line 0 it shifts out the read opcode 0x6B followed by the address. Eight dummy clocks follow, and during them line 0 turns around from output to input. After that it samples all four lines on every rising clock edge and joins each pair of nibbles into a byte. Each byte appears on `data_o` with a one-cycle `valid_o` strobe. The flash advances its address by itself, so any byte count is served by one command.

The serial clock runs at a programmable fraction of the system clock. The idle clock level is selectable, so the block works with flashes in either clock mode 0 or mode 3. A start is refused with an error pulse unless the flash's quad-enable bit is reported set. A zero byte count finishes at once. After every command, chip select stays high for at least one serial clock period before `done_o` pulses.

Top module: `qspi_quad_reader`

## Requirements
- R1: After reset, `cs_no` is 1, `sck_o` is 0, `io_oe_o` is 0000, and `valid_o`, `done_o`, `err_o` and `busy_o` are all 0.
- R2: Serial clocks are numbered from 0 after chip select falls. During clocks 0–7, `io_o[0]` carries opcode 0x6B with the MSB first. During clocks 8–31 it carries the address with bit 23 first. Each bit changes on a falling edge or at chip select low, and it is stable at the following rising edge. `io_oe_o[0]` is 1 only during these clocks.
- R3: Clocks 32–39 are dummy clocks. `io_oe_o[0]` drops at the falling edge that begins clock 32. `io_oe_o[3:1]` is always 000.
- R4: From clock 40 on, `io_i` is sampled at each rising edge. Each byte takes two clocks: the first nibble is bits 7..4 and the second is bits 3..0, with `io_i[3]` carrying the highest bit of each nibble. `valid_o` pulses for one cycle for each byte, with the byte on `data_o`.
- R5: Exactly `len_i` bytes are delivered in address order, all under one chip select low period of 40 + 2·`len_i` serial clocks.
- R6: A serial clock half-period lasts h = max(`div_i`,1) system clocks, latched at start. When chip select is high, `sck_o` rests at `mode3_i` (1 = idle high).
- R7: Take the accepted start edge as cycle 0, and let N = 40 + 2·`len_i`. `cs_no` is 0 from cycle 0 up to cycle h·(2N+1). `done_o` is a single-cycle pulse at cycle h·(2N+3), which leaves at least one serial clock period with chip select high.
- R8: A start while `qe_ok_i` is 0 gives a one-cycle `err_o` pulse. In that case `cs_no` stays 1 and `done_o` does not pulse.
- R9: A start with `len_i` = 0 and `qe_ok_i` = 1 pulses `done_o` in the next cycle without lowering `cs_no`.
- R10: A start pulse while `busy_o` is 1 is ignored. The running transfer's timing and data are unchanged, and no error is raised.
- R11: `busy_o` is 1 from the cycle after an accepted non-empty start until `done_o` pulses, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| addr_i | input | 24 | Flash start address |
| len_i | input | LEN_W | Number of bytes to read |
| div_i | input | DIV_W | Serial clock half-period in system clocks (0 treated as 1) |
| mode3_i | input | 1 | Idle clock level: 0 low (mode 0), 1 high (mode 3) |
| qe_ok_i | input | 1 | Flash quad-enable bit is set |
| cs_no | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| io_o | output | 4 | Data line output values |
| io_oe_o | output | 4 | Data line output enables, one per line |
| io_i | input | 4 | Data line input values |
| data_o | output | 8 | Assembled read byte |
| valid_o | output | 1 | One-cycle strobe for `data_o` |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a start refused for lack of quad enable |
| busy_o | output | 1 | Command in progress |

## Verification
The bench builds the block with an 8-bit byte count and a 4-bit divider. This keeps each command short, so the full 40-clock preamble and several data bytes run many times within the cycle budget. The narrow divider still covers the clamp of 0 to a one-cycle half-period, the fastest setting and an odd setting of 3. This exercises sampling both right after the falling edge and several cycles later. It also places the chip-select and done timing formula at several different scales, in both idle clock levels, and across a 24-bit address wrap.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_RUN, ST_GAP} state_t;

  localparam logic [7:0] QREAD_OP   = 8'h6B;
  localparam int         ADDR_W     = 24;
  localparam int         CMD_W      = 8 + ADDR_W;
  localparam int         DUMMY_CLKS = 8;
  localparam int         DATA_START = CMD_W + DUMMY_CLKS;
  localparam int         LANES      = 4;
endpackage

// File: rtl/qrd_half_timer.sv
module qrd_half_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] half_len_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == half_len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qrd_cmd_shift.sv
module qrd_cmd_shift #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  assign msb_o = sr_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= load_val_i;
    else if (shift_i)  sr_q <= {sr_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/qrd_nibble_pack.sv
module qrd_nibble_pack (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic       lo_i,
  input  logic [3:0] nib_i,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  logic [3:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        if (!lo_i) begin
          hi_q <= nib_i;
        end else begin
          byte_o  <= {hi_q, nib_i};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader
  import qrd_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DIV_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 mode3_i,
  input  logic                 qe_ok_i,
  output logic                 cs_no,
  output logic                 sck_o,
  output logic [LANES-1:0]     io_o,
  output logic [LANES-1:0]     io_oe_o,
  input  logic [LANES-1:0]     io_i,
  output logic [7:0]           data_o,
  output logic                 valid_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 busy_o
);
  // clock index must hold DATA_START + 2*(2^LEN_W - 1)
  localparam int IDX_W = LEN_W + 7;

  state_t             state_q;
  logic               cs_q, sck_q, mode_q, high_q, done_q, err_q;
  logic [DIV_W-1:0]   half_q;
  logic [IDX_W-1:0]   idx_q, last_q;
  logic               tick, accept, launch, samp, shift, drv0, cmd_msb;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign launch = accept && qe_ok_i && (len_i != '0);
  assign samp   = (state_q == ST_RUN) && tick && !high_q;
  assign shift  = (state_q == ST_RUN) && tick && high_q;
  assign drv0   = ((state_q == ST_PRE) || (state_q == ST_RUN)) &&
                  (idx_q < IDX_W'(CMD_W));

  qrd_half_timer #(.CNT_W(DIV_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q == ST_IDLE),
    .half_len_i(half_q),
    .tick_o    (tick)
  );

  qrd_cmd_shift #(.W(CMD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (launch),
    .load_val_i({QREAD_OP, addr_i}),
    .shift_i   (shift),
    .msb_o     (cmd_msb)
  );

  qrd_nibble_pack u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (samp && (idx_q >= IDX_W'(DATA_START))),
    .lo_i   (idx_q[0]),
    .nib_i  (io_i),
    .byte_o (data_o),
    .valid_o(valid_o)
  );

  // single-line command on lane 0, upper lanes only ever listen
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_cmd
      assign io_o[l]    = cmd_msb;
      assign io_oe_o[l] = drv0;
    end else begin : g_rx
      assign io_o[l]    = 1'b0;
      assign io_oe_o[l] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      mode_q  <= 1'b0;
      high_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      half_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sck_q <= mode3_i;
          if (accept) begin
            if (!qe_ok_i) begin
              err_q <= 1'b1;
            end else if (len_i == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_PRE;
              cs_q    <= 1'b0;
              mode_q  <= mode3_i;
              half_q  <= (div_i == '0) ? DIV_W'(1) : div_i;
              idx_q   <= '0;
              high_q  <= 1'b0;
              last_q  <= IDX_W'(DATA_START - 1) + IDX_W'({len_i, 1'b0});
            end
          end
        end
        // chip select setup, clock held at its idle level
        ST_PRE: if (tick) begin
          sck_q   <= 1'b0;
          state_q <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          if (!high_q) begin
            sck_q  <= 1'b1;
            high_q <= 1'b1;
          end else if (idx_q == last_q) begin
            state_q <= ST_GAP;
            cs_q    <= 1'b1;
            sck_q   <= mode_q;
            high_q  <= 1'b0;
          end else begin
            sck_q  <= 1'b0;
            high_q <= 1'b0;
            idx_q  <= idx_q + 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          if (high_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            high_q  <= 1'b0;
          end else begin
            high_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no  = cs_q;
  assign sck_o  = sck_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/qrd_checker.sv
module qrd_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             qe_ok_i,
  input logic [LEN_W-1:0] len_i,
  input logic             cs_no,
  input logic [3:0]       io_oe_o,
  input logic             valid_o,
  input logic             done_o,
  input logic             err_o,
  input logic             busy_o
);
  AST_UPPER_LANES_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o[3:1] == 3'b000); // R3
  AST_DRIVE_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o[0] |-> !cs_no); // R2
  AST_VALID_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !cs_no); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !busy_o)); // R7
  AST_REFUSE_NO_QE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !qe_ok_i) |=> (err_o && cs_no && !done_o)); // R8
  AST_ZERO_LEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && qe_ok_i && len_i == '0) |=> (done_o && cs_no)); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> !err_o); // R10
  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no); // R11
endmodule

bind qspi_quad_reader qrd_checker #(.LEN_W(LEN_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .qe_ok_i(qe_ok_i),
  .len_i  (len_i),
  .cs_no  (cs_no),
  .io_oe_o(io_oe_o),
  .valid_o(valid_o),
  .done_o (done_o),
  .err_o  (err_o),
  .busy_o (busy_o)
);

// File: tb/sim_qspi_quad_reader.sv
module sim_qspi_quad_reader;
  localparam int LEN_W = 8;
  localparam int DIV_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [23:0]      addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [DIV_W-1:0] div_i = '0;
  logic             mode3_i = 1'b0;
  logic             qe_ok_i = 1'b1;
  logic             cs_no, sck_o, valid_o, done_o, err_o, busy_o;
  logic [3:0]       io_o, io_oe_o;
  logic [3:0]       io_i = 4'h0;
  logic [7:0]       data_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  qspi_quad_reader #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .len_i(len_i), .div_i(div_i), .mode3_i(mode3_i), .qe_ok_i(qe_ok_i),
    .cs_no(cs_no), .sck_o(sck_o), .io_o(io_o), .io_oe_o(io_oe_o),
    .io_i(io_i), .data_o(data_o), .valid_o(valid_o), .done_o(done_o),
    .err_o(err_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return m ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // flash model: watches SCK at the system clock falling edge
  int          rises = 0, last_rise = 0, exp_n = 0, exp_h = 1;
  bit          seen_rise = 1'b0;
  logic [31:0] cmd = '0;
  logic        prev_sck = 1'b0, prev_cs = 1'b1;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_cs && !cs_no) begin
        rises = 0;
        cmd = '0;
        seen_rise = 1'b0;
      end else if (!prev_cs && cs_no) begin
        chk(cmd == {8'h6B, addr_i}, "R2", "opcode+address", cmd, {8'h6B, addr_i});
        chk(rises == exp_n, "R5", "sck clocks per command", rises, exp_n);
      end else if (!cs_no) begin
        if (!prev_sck && sck_o) begin
          if (rises < 32) begin
            chk(io_oe_o == 4'b0001, "R2", "io0 driven in command", io_oe_o, 1);
            cmd = {cmd[30:0], io_o[0]};
          end else begin
            chk(io_oe_o == 4'b0000, "R3", "lines released after clock 31", io_oe_o, 0);
          end
          if (seen_rise)
            chk(cyc - last_rise == 2 * exp_h, "R6", "sck period", cyc - last_rise, 2 * exp_h);
          seen_rise = 1'b1;
          last_rise = cyc;
          rises++;
        end else if (prev_sck && !sck_o) begin
          if (rises >= 32)
            chk(io_oe_o == 4'b0000, "R3", "release by falling edge of clock 32", io_oe_o, 0);
          if (rises >= 40) begin
            automatic int k = rises - 40;
            automatic logic [7:0] b = mem_byte(cmd[23:0] + 24'(k / 2));
            io_i = (k % 2 == 0) ? b[7:4] : b[3:0];
          end
        end
      end
      prev_sck = sck_o;
      prev_cs  = cs_no;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected byte", data_o, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(data_o == e, "R4", "read byte", data_o, e);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "R7", "watchdog", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic xfer(input logic [23:0] a, input int len, input int dv,
                      input bit m3, input bit inject);
    int h, n, csl, dn;
    h   = (dv == 0) ? 1 : dv;
    n   = 40 + 2 * len;
    csl = h * (2 * n + 1);
    dn  = h * (2 * n + 3);
    @(negedge clk_i);
    div_i = DIV_W'(dv);
    mode3_i = m3;
    repeat (2) @(negedge clk_i);
    chk(sck_o == m3, "R6", "idle clock level", sck_o, m3);
    exp_n = n;
    exp_h = h;
    for (int i = 0; i < len; i++) exp_q.push_back(mem_byte(a + 24'(i)));
    addr_i = a;
    len_i = LEN_W'(len);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int e = 0; e <= dn + 1; e++) begin
      chk(cs_no == (e >= csl), "R7", "chip select window", cs_no, e >= csl);
      chk(done_o == (e == dn), "R7", "done pulse cycle", done_o, e == dn);
      chk(busy_o == (e < dn), "R11", "busy window", busy_o, e < dn);
      chk(!err_o, "R10", "no error during transfer", err_o, 0);
      if (e >= csl) chk(sck_o == m3, "R6", "clock rests at idle", sck_o, m3);
      if (inject && (e == 20 || e == csl + 1)) begin
        addr_i = ~a;
        len_i = LEN_W'(1);
        start_i = 1'b1;
      end else begin
        addr_i = a;
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    chk(exp_q.size() == 0, "R5", "bytes outstanding", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cs_no == 1'b1, "R1", "reset cs", cs_no, 1);
    chk(sck_o == 1'b0, "R1", "reset sck", sck_o, 0);
    chk(io_oe_o == 4'b0, "R1", "reset oe", io_oe_o, 0);
    chk({valid_o, done_o, err_o, busy_o} == 4'b0, "R1", "reset flags",
        {valid_o, done_o, err_o, busy_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    xfer(24'h123456, 3, 1, 1'b0, 1'b0);   // R2 R4 fastest, mode 0
    xfer(24'hFFFFFE, 5, 3, 1'b1, 1'b0);   // R6 odd divider, mode 3, address wrap
    xfer(24'h00A0F0, 2, 0, 1'b0, 1'b0);   // R6 divider 0 clamps to 1
    xfer(24'h5A5A5A, 4, 2, 1'b1, 1'b1);   // R10 start while busy ignored

    // R9 zero length
    @(negedge clk_i);
    qe_ok_i = 1'b1; len_i = '0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R9", "zero length done", done_o, 1);
    chk(cs_no == 1'b1 && busy_o == 1'b0, "R9", "zero length no select", {cs_no, busy_o}, 2);
    @(negedge clk_i);
    chk(done_o == 1'b0 && cs_no == 1'b1, "R9", "zero length after", {done_o, cs_no}, 1);

    // R8 quad enable missing
    qe_ok_i = 1'b0; len_i = LEN_W'(4); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R8", "refused start error", err_o, 1);
    chk(done_o == 1'b0 && cs_no == 1'b1 && busy_o == 1'b0, "R8", "refused no command",
        {done_o, cs_no, busy_o}, 2);
    repeat (3) begin
      @(negedge clk_i);
      chk(err_o == 1'b0 && cs_no == 1'b1, "R8", "refused stays idle", {err_o, cs_no}, 1);
    end
    qe_ok_i = 1'b1;

    xfer(24'h000000, 1, 1, 1'b1, 1'b0);   // R4 single byte, mode 3

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule